// File: doc/BRIEF.md
# Debug Event Status and PC Capture Unit

This block is the status side of an on-chip debug event facility. Hardware event detectors outside the block report breakpoint end, trace end, trace trigger, interrupt end and four counter underflows. Each report sets a sticky flag, and the flag stays set until software clears it. Software reaches the block through a small word-addressed register port. A write-only command word carries per-bit actions that clear flags or fire software trace pulses. The same word also holds a 10-bit indirect address field.

A 64-bit capture register follows the live program counter on every cycle while the selected trigger is inactive. It keeps the PC of the cycle in which the trigger became active, for as long as the trigger stays active. Once the trigger falls, it resumes tracking.

The register port has no flow control. A write takes effect at the clock edge on which `reg_wr_en` is high, and reads are combinational from `reg_addr`. Register map:

| Word | Contents |
|---|---|
| 0 | Command register |
| 1 | Status flags |
| 2 | Captured PC, bits 31:0 |
| 3 | Captured PC, bits 63:32 |

Status flags sit in word 1 as follows. The upper bits of word 1 read 0.

| Bit | Flag |
|---|---|
| 0 | Breakpoint end |
| 1 | Trace end |
| 2 | Trace trigger |
| 3 | Interrupt end |
| 7:4 | Counter underflow 3..0, one bit per counter (bit 4 is counter 0) |

Top module: `dbg_evt_unit`

## Requirements
- R1: After reset, status word 1 reads 0, command word 0 reads 0, and both trace pulse outputs are low.
- R2: Each event input sets its status flag at the next clock edge. The flag stays set until a command write clears it.
- R3: Writing command word 0 with bit 31 = 1 clears the breakpoint-end flag (status bit 0). A 0 in bit 31 leaves the flag unchanged.
- R4: Writing command bit 30 = 1 clears the trace-end flag (status bit 1) and the trace-trigger flag (status bit 2) in the same write.
- R5: Command bits 27:24 act per counter. A 1 in bit 24+n clears underflow flag n (status bit 4+n). Underflow flags whose command bit is 0 keep their value.
- R6: Writing command bit 21 = 1 clears the interrupt-end flag (status bit 3).
- R7: A command write with bit 23 = 1 drives `trace_trig_out` high during that write cycle only, and it sets the trace-trigger flag. A command write with bit 22 = 1 drives `trace_end_out` high during that write cycle only.
- R8: When a set (from an event input or a software trigger) and a clear of the same flag happen in the same cycle, the flag ends up set.
- R9: In a read of command word 0, bits 31:10 always return 0, whatever was written. Bits 9:0 return the last value written to them.
- R10: While `trig_active` is low, words 2 and 3 return the value `pc_live` had at the previous clock edge.
- R11: In the first cycle in which `trig_active` is high, the block loads `pc_live` into the capture register. It then holds that value while `trig_active` stays high, and tracks `pc_live` again once `trig_active` is low.
- R12: Word 2 returns captured PC bits 31:0, and word 3 returns bits 63:32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| evt_bp_end | input | 1 | Breakpoint end event |
| evt_trace_end | input | 1 | Trace end event |
| evt_trace_trig | input | 1 | Trace trigger event |
| evt_int_end | input | 1 | Interrupt end event |
| evt_cnt_udf | input | 4 | Counter underflow events, one per counter |
| trig_active | input | 1 | Selected trigger event level |
| pc_live | input | 64 | Live program counter |
| trace_trig_out | output | 1 | Software trace trigger pulse |
| trace_end_out | output | 1 | Software trace end pulse |

## Verification
The hardest case to reach from the ports is a set and a clear of the same flag in the same cycle. This includes a software trigger that also clears its own flag in one command word. The stimulus table places event inputs and command writes in the same row and carries the expected flag word from row to row, so each collision is checked against the known prior state. For PC capture, the bench changes `pc_live` while the trigger is held. This shows that the register kept the first trigger-cycle value and did not keep the value from the cycle before.

// File: rtl/dbg_evt_pkg.sv
package dbg_evt_pkg;
  localparam int DATA_W  = 32;
  localparam int NUM_UDF = 4;
  localparam int IND_AW  = 10;
  localparam int STAT_W  = 4 + NUM_UDF;
  localparam int PC_W    = 2 * DATA_W;

  // status flag positions
  localparam int ST_BP    = 0;
  localparam int ST_TEND  = 1;
  localparam int ST_TTRIG = 2;
  localparam int ST_IEND  = 3;
  localparam int ST_UDF0  = 4;

  // command word action bits
  localparam int CMD_CLR_BP   = 31;
  localparam int CMD_CLR_TRC  = 30;
  localparam int CMD_CLR_UDF0 = 24;
  localparam int CMD_SW_TRIG  = 23;
  localparam int CMD_SW_END   = 22;
  localparam int CMD_CLR_IEND = 21;

  typedef enum logic [1:0] {
    RA_CMD  = 2'd0,
    RA_STAT = 2'd1,
    RA_PCLO = 2'd2,
    RA_PCHI = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/dbg_cmd_decode.sv
module dbg_cmd_decode
  import dbg_evt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [STAT_W-1:0] clr_vec,
  output logic              sw_trig,
  output logic              sw_end,
  output logic [IND_AW-1:0] ind_addr_q
);
  logic unused_rsvd;
  assign unused_rsvd = ^{wdata[29:28], wdata[20:IND_AW]};

  // Action bits: decoded only in the write cycle, never stored
  always_comb begin
    clr_vec = '0;
    if (cmd_wr) begin
      clr_vec[ST_BP]    = wdata[CMD_CLR_BP];
      clr_vec[ST_TEND]  = wdata[CMD_CLR_TRC];
      clr_vec[ST_TTRIG] = wdata[CMD_CLR_TRC];
      clr_vec[ST_IEND]  = wdata[CMD_CLR_IEND];
      clr_vec[ST_UDF0 +: NUM_UDF] = wdata[CMD_CLR_UDF0 +: NUM_UDF];
    end
  end

  assign sw_trig = cmd_wr & wdata[CMD_SW_TRIG];
  assign sw_end  = cmd_wr & wdata[CMD_SW_END];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ind_addr_q <= '0;
    else if (cmd_wr) ind_addr_q <= wdata[IND_AW-1:0];
  end
endmodule

// File: rtl/dbg_status_flags.sv
module dbg_status_flags #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] flags_q
);
  for (genvar i = 0; i < W; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flags_q[i] <= 1'b0;
      else if (set_vec[i]) flags_q[i] <= 1'b1;   // set has priority
      else if (clr_vec[i]) flags_q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/dbg_pc_capture.sv
module dbg_pc_capture #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         trig_active,
  input  logic [W-1:0] pc_live,
  output logic [W-1:0] pc_cap_q
);
  logic trig_d;
  logic load;

  // load while idle and in the first active cycle; hold afterwards
  assign load = !trig_active || !trig_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_d   <= 1'b0;
      pc_cap_q <= '0;
    end else begin
      trig_d <= trig_active;
      if (load) pc_cap_q <= pc_live;
    end
  end
endmodule

// File: rtl/dbg_evt_unit.sv
module dbg_evt_unit
  import dbg_evt_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr_en,
  input  logic [1:0]            reg_addr,
  input  logic [DATA_W-1:0]     reg_wdata,
  output logic [DATA_W-1:0]     reg_rdata,
  input  logic                  evt_bp_end,
  input  logic                  evt_trace_end,
  input  logic                  evt_trace_trig,
  input  logic                  evt_int_end,
  input  logic [NUM_UDF-1:0]    evt_cnt_udf,
  input  logic                  trig_active,
  input  logic [PC_W-1:0]       pc_live,
  output logic                  trace_trig_out,
  output logic                  trace_end_out
);
  logic              cmd_wr;
  logic [STAT_W-1:0] clr_vec;
  logic [STAT_W-1:0] set_vec;
  logic [STAT_W-1:0] stat_q;
  logic [IND_AW-1:0] ind_addr_q;
  logic [PC_W-1:0]   pc_cap;
  logic              sw_trig;
  logic              sw_end;

  assign cmd_wr = reg_wr_en && (reg_addr == RA_CMD);

  dbg_cmd_decode u_cmd (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_wr     (cmd_wr),
    .wdata      (reg_wdata),
    .clr_vec    (clr_vec),
    .sw_trig    (sw_trig),
    .sw_end     (sw_end),
    .ind_addr_q (ind_addr_q)
  );

  always_comb begin
    set_vec                     = '0;
    set_vec[ST_BP]              = evt_bp_end;
    set_vec[ST_TEND]            = evt_trace_end;
    set_vec[ST_TTRIG]           = evt_trace_trig | sw_trig;
    set_vec[ST_IEND]            = evt_int_end;
    set_vec[ST_UDF0 +: NUM_UDF] = evt_cnt_udf;
  end

  dbg_status_flags #(.W(STAT_W)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .flags_q (stat_q)
  );

  dbg_pc_capture #(.W(PC_W)) u_pc (
    .clk         (clk),
    .rst_n       (rst_n),
    .trig_active (trig_active),
    .pc_live     (pc_live),
    .pc_cap_q    (pc_cap)
  );

  assign trace_trig_out = sw_trig;
  assign trace_end_out  = sw_end;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_CMD:  reg_rdata[IND_AW-1:0] = ind_addr_q;
      RA_STAT: reg_rdata[STAT_W-1:0] = stat_q;
      RA_PCLO: reg_rdata = pc_cap[DATA_W-1:0];
      default: reg_rdata = pc_cap[PC_W-1:DATA_W];
    endcase
  end
endmodule

// File: rtl/dbg_evt_unit_chk.sv
module dbg_evt_unit_chk
  import dbg_evt_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  reg_wr_en,
  input logic [1:0]            reg_addr,
  input logic [DATA_W-1:0]     reg_wdata,
  input logic [DATA_W-1:0]     reg_rdata,
  input logic                  evt_bp_end,
  input logic                  evt_int_end,
  input logic [NUM_UDF-1:0]    evt_cnt_udf,
  input logic                  trig_active,
  input logic [PC_W-1:0]       pc_live,
  input logic                  trace_trig_out,
  input logic                  trace_end_out,
  input logic [STAT_W-1:0]     stat_q,
  input logic [PC_W-1:0]       pc_cap
);
  logic wr_c;
  assign wr_c = reg_wr_en && (reg_addr == 2'd0);

  AST_STICKY_BP: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q[ST_BP] && !(wr_c && reg_wdata[CMD_CLR_BP]) |=> stat_q[ST_BP]); // R2
  AST_CLR_BP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_c && reg_wdata[CMD_CLR_BP] && !evt_bp_end |=> !stat_q[ST_BP]); // R3
  AST_CLR_UDF0: assert property (@(posedge clk) disable iff (!rst_n)
    wr_c && reg_wdata[CMD_CLR_UDF0] && !evt_cnt_udf[0] |=> !stat_q[ST_UDF0]); // R5
  AST_PULSE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (trace_trig_out || trace_end_out) |-> wr_c); // R7
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_int_end |=> stat_q[ST_IEND]); // R8
  AST_CMD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr == 2'd0 |-> reg_rdata[DATA_W-1:IND_AW] == '0); // R9
  AST_PC_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    !trig_active |=> pc_cap == $past(pc_live)); // R10
  AST_PC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    trig_active ##1 trig_active |=> $stable(pc_cap)); // R11
endmodule

bind dbg_evt_unit dbg_evt_unit_chk u_chk (.*);

// File: tb/tb_dbg_evt_unit.sv
`timescale 1ns/1ps
module tb_dbg_evt_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [7:0]  ev = '0;
  logic        trig_active = 1'b0;
  logic [63:0] pc_live = '0;
  logic        trace_trig_out, trace_end_out;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  dbg_evt_unit dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .evt_bp_end(ev[0]), .evt_trace_end(ev[1]), .evt_trace_trig(ev[2]),
    .evt_int_end(ev[3]), .evt_cnt_udf(ev[7:4]),
    .trig_active(trig_active), .pc_live(pc_live),
    .trace_trig_out(trace_trig_out), .trace_end_out(trace_end_out));

  // {events[7:0], write, cmd word[31:0], expected status[7:0]}
  localparam int NV = 12;
  localparam logic [48:0] VEC [NV] = '{
    {8'h01, 1'b0, 32'h0000_0000, 8'h01},  // R2 set bp
    {8'hFF, 1'b0, 32'h0000_0000, 8'hFF},  // R2 set all
    {8'h00, 1'b1, 32'h8000_0000, 8'hFE},  // R3
    {8'h00, 1'b1, 32'h4000_0000, 8'hF8},  // R4
    {8'h00, 1'b1, 32'h0500_0000, 8'hA8},  // R5 udf0,udf2
    {8'h00, 1'b1, 32'h0020_0000, 8'hA0},  // R6
    {8'h00, 1'b1, 32'h0080_0000, 8'hA4},  // R7 sw trig sets flag
    {8'h01, 1'b1, 32'h8000_0000, 8'hA5},  // R8 event beats clear
    {8'h00, 1'b1, 32'h0A00_0000, 8'h05},  // R5 udf1,udf3
    {8'h00, 1'b1, 32'h0000_0000, 8'h05},  // R3 zero write no effect
    {8'h04, 1'b1, 32'h4000_0000, 8'h05},  // R8 trig set vs clear
    {8'h00, 1'b1, 32'hC0A0_0000, 8'h04}   // R8 sw trig beats own clear
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_wr_en = 1'b0;
    reg_addr  = a;
    #1;
    d = reg_rdata;
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d, d2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(2'd1, d); chk("R1 status", d, 0);
    rd(2'd0, d); chk("R1 cmd", d, 0);
    chk("R1 pulses", {trace_trig_out, trace_end_out}, 0);

    for (int i = 0; i < NV; i++) begin
      ev        = VEC[i][48:41];
      reg_wr_en = VEC[i][40];
      reg_addr  = 2'd0;
      reg_wdata = VEC[i][39:8];
      @(negedge clk);
      ev = '0;
      rd(2'd1, d);
      chk($sformatf("R2..R8 row %0d", i), d, {24'h0, VEC[i][7:0]});
    end

    // R7 pulses exist only in write cycle
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = 2'd0; reg_wdata = 32'h0040_0000; #1;
    chk("R7 end pulse", {trace_trig_out, trace_end_out}, 2'b01);
    @(negedge clk);
    reg_wdata = 32'h0080_0000; #1;
    chk("R7 trig pulse", {trace_trig_out, trace_end_out}, 2'b10);
    @(negedge clk);
    rd(2'd1, d);
    chk("R7 pulse gone", {trace_trig_out, trace_end_out}, 2'b00);

    // R9 command readback
    reg_wr_en = 1'b1; reg_addr = 2'd0; reg_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    rd(2'd0, d); chk("R9 cmd all ones", d, 32'h0000_03FF);
    reg_wr_en = 1'b1; reg_addr = 2'd0; reg_wdata = 32'h0000_0155;
    @(negedge clk);
    rd(2'd0, d); chk("R9 cmd addr field", d, 32'h0000_0155);

    // R10/R12 tracking
    pc_live = 64'h1234_5678_9ABC_DEF0;
    @(negedge clk);
    rd(2'd2, d); rd(2'd3, d2);
    chk("R10 R12 track", {d2, d}, 64'h1234_5678_9ABC_DEF0);

    // R11 freeze on first trigger cycle
    trig_active = 1'b1; pc_live = 64'hAAAA_0000_BBBB_0001;
    @(negedge clk);
    pc_live = 64'hCCCC_0000_DDDD_0002;
    @(negedge clk);
    pc_live = 64'hEEEE_0000_FFFF_0003;
    @(negedge clk);
    rd(2'd2, d); rd(2'd3, d2);
    chk("R11 frozen", {d2, d}, 64'hAAAA_0000_BBBB_0001);
    trig_active = 1'b0; pc_live = 64'h0101_0202_0303_0404;
    @(negedge clk);
    rd(2'd2, d); rd(2'd3, d2);
    chk("R11 resume", {d2, d}, 64'h0101_0202_0303_0404);

    // R1 reset again clears flags
    ev = 8'hFF; @(negedge clk); ev = '0;
    rst_n = 1'b0; #1; rst_n = 1'b1;
    rd(2'd1, d); chk("R1 reset clears", d, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule